// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a legacy PC multi-function I/O device. It sits on an 8-bit I/O bus with a 16-bit address. It answers at two addresses: an index port at 0x3F0 and a data port at 0x3F1. Behind them is a file of sixteen 8-bit configuration registers. The file is closed after reset. Software opens it by writing the key byte 0x55 twice in a row to the index port. It closes it again by writing 0xAA to the index port.

While the file is open, any other byte written to the index port selects a register. The data port then reads or writes the selected register. The register contents are decoded straight into configuration outputs for the neighbouring functions:
- parallel port base and enable
- the COM3/COM4 base pair
- base, enable and IRQ for each of the two serial ports
- floppy enhanced mode, density-select force and drive swap

A one-cycle change strobe fires for each field group whose bits actually changed. The block also drives an enable that lets the floppy controller keep its own decode of 0x3F1. That enable drops while the configuration file holds the data port.

Top module: `sio_cfg_port`

## Requirements
- R1: Only ioAddr 0x3F0 (index port) and 0x3F1 (data port) are decoded; writes to any other address, including ones that differ only in bits 15:10, change no state.
- R2: The block keeps the last two bytes pushed into a key history (newer slot, older slot; each push moves newer to older). It is unlocked exactly when both slots hold 0x55. Reset clears both slots to 0x00, so the block starts locked.
- R3: While locked, each index-port write is pushed into the history and never alters the selected register index.
- R4: While unlocked, an index-port write of 0xAA is pushed into the history, which locks the block. Any other index-port byte becomes the selected index. Reset sets the index to 0.
- R5: fdcDataDecodeEn resets to 1. It drops to 0 one cycle after a history push of 0x55 while the newer slot already holds 0x55. It returns to 1 one cycle after a history push of a non-0x55 byte while both slots hold 0x55.
- R6: ioRdData is combinational. It equals the selected register when ioAddr is 0x3F1, the block is unlocked and the index is 15 or less. Otherwise it is 0xFF.
- R7: A data-port write updates the selected register only when the block is unlocked and the index is 15 or less; otherwise it is ignored.
- R8: Reset values are: register 0 = 0x3A, 1 = 0x9F, 2 = 0xDC, 3 = 0x78, 6 = 0xFF, 14 = 0x01, 13 = the DEVICE_ID parameter (default 0x63), and 0x00 for all others.
- R9: Register 1 bits 1:0 set the parallel port. 0 gives lptEn=0 and lptBase=0. 1, 2 and 3 give lptEn=1 with lptBase 0x3BC, 0x378 and 0x278.
- R10: Register 1 bits 6:5 set {com3Base, com4Base}: 0 = 0x338/0x238, 1 = 0x3E8/0x2E8, 2 = 0x3E8/0x2E0, 3 = 0x220/0x228.
- R11: Register 2 bit 2 is ser1En and bits 1:0 its select. Bit 6 is ser2En and bits 5:4 its select. Each select maps 0 to 0x3F8 with IRQ 4, 1 to 0x2F8 with IRQ 3, 2 to com3Base with IRQ 4, and 3 to com4Base with IRQ 3.
- R12: fdcEnhMode is register 3 bit 1, fdcDenselForce is register 5 bits 4:3, and fdcDriveSwap is register 5 bit 5.
- R13: In the cycle after an accepted data write, each strobe is 1 exactly when its field changed (old XOR new):
  - lptUpd: register 1 bits 1:0
  - com34Upd: register 1 bits 6:5
  - ser1Upd: register 2 bits 2:0
  - ser2Upd: register 2 bits 6:4
  - fdcUpd: register 3 bit 1 or register 5 bits 5:3

  The decoded outputs change in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 8 | I/O write data |
| ioWr | input | 1 | I/O write strobe, one cycle per access |
| ioRdData | output | 8 | Data-port read value |
| fdcDataDecodeEn | output | 1 | Floppy controller may decode 0x3F1 |
| lptEn | output | 1 | Parallel port enabled |
| lptBase | output | 10 | Parallel port base |
| com3Base | output | 10 | COM3 base |
| com4Base | output | 10 | COM4 base |
| ser1En | output | 1 | Serial port 1 enabled |
| ser1Base | output | 10 | Serial port 1 base |
| ser1Irq | output | 4 | Serial port 1 IRQ |
| ser2En | output | 1 | Serial port 2 enabled |
| ser2Base | output | 10 | Serial port 2 base |
| ser2Irq | output | 4 | Serial port 2 IRQ |
| fdcEnhMode | output | 1 | Floppy enhanced mode |
| fdcDenselForce | output | 2 | Density-select force code |
| fdcDriveSwap | output | 1 | Drive swap |
| lptUpd | output | 1 | Parallel select changed |
| com34Upd | output | 1 | COM3/COM4 pair changed |
| ser1Upd | output | 1 | Serial 1 select changed |
| ser2Upd | output | 1 | Serial 2 select changed |
| fdcUpd | output | 1 | Floppy mode bits changed |

## Verification
The tricky overlap is a change strobe from a data write landing in the same cycle as a locking write to the index port. The bench provokes it by issuing a data write to register 1 and, with no idle cycle, an index write of 0xAA. It then judges three things:
- the strobe is high while the lock write is being taken;
- afterwards, reads return 0xFF and the decode enable is back on;
- the new parallel base remains in force.

A second overlap is checked the same way: a data-port write issued while locked. It must be ignored even though the key history moves in nearby cycles.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'h55;
  localparam logic [7:0] LOCK_KEY   = 8'hAA;
  localparam logic [7:0] READ_IDLE  = 8'hFF;

  // Command handed from control to datapath
  typedef struct packed {
    logic       regWr;
    logic [3:0] regIdx;
    logic [7:0] wrData;
  } cfgCmd_t;

  // Change strobes, one per field group
  typedef struct packed {
    logic lpt;
    logic com34;
    logic ser1;
    logic ser2;
    logic fdc;
  } cfgUpd_t;
endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h03F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              ioWr,
  output cfgCmd_t           cmd,
  output logic              unlocked,
  output logic              idxValid,
  output logic [3:0]        curIdx,
  output logic              fdcDataDecodeEn
);
  localparam logic [ADDR_W-1:0] DATA_PORT = IDX_PORT + 1'b1;

  logic [DATA_W-1:0] histOld, histNew, idxReg;
  logic idxHit, dataHit, histPush;

  assign unlocked = (histOld == UNLOCK_KEY) && (histNew == UNLOCK_KEY);
  assign idxHit   = ioWr && (ioAddr == IDX_PORT);
  assign dataHit  = ioWr && (ioAddr == DATA_PORT);
  assign histPush = idxHit && (!unlocked || ioWrData == LOCK_KEY);
  assign idxValid = (idxReg < DATA_W'(NUM_REGS));
  assign curIdx   = idxReg[3:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histOld         <= '0;
      histNew         <= '0;
      idxReg          <= '0;
      fdcDataDecodeEn <= 1'b1;
    end else if (histPush) begin
      histOld <= histNew;
      histNew <= ioWrData;
      if (ioWrData == UNLOCK_KEY && histNew == UNLOCK_KEY)
        fdcDataDecodeEn <= 1'b0;
      else if (unlocked && ioWrData != UNLOCK_KEY)
        fdcDataDecodeEn <= 1'b1;
    end else if (idxHit) begin
      idxReg <= ioWrData;
    end
  end

  always_comb begin
    cmd.regWr  = dataHit && unlocked && idxValid;
    cmd.regIdx = idxReg[3:0];
    cmd.wrData = ioWrData;
  end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter logic [7:0] DEVICE_ID = 8'h63
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgCmd_t    cmd,
  input  logic [3:0] rdIdx,
  output logic [7:0] rdReg,
  output cfgUpd_t    upd,
  output logic       lptEn,
  output logic [9:0] lptBase,
  output logic [9:0] com3Base,
  output logic [9:0] com4Base,
  output logic       ser1En,
  output logic [9:0] ser1Base,
  output logic [3:0] ser1Irq,
  output logic       ser2En,
  output logic [9:0] ser2Base,
  output logic [3:0] ser2Irq,
  output logic       fdcEnhMode,
  output logic [1:0] fdcDenselForce,
  output logic       fdcDriveSwap
);
  logic [7:0] cfgRegs [NUM_REGS];
  logic [7:0] diff;

  function automatic logic [7:0] resetVal(int i);
    case (i)
      0:       return 8'h3A;
      1:       return 8'h9F;
      2:       return 8'hDC;
      3:       return 8'h78;
      6:       return 8'hFF;
      13:      return DEVICE_ID;
      14:      return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [9:0] serBaseOf(logic [1:0] sel, logic [9:0] c3, logic [9:0] c4);
    case (sel)
      2'd0:    return 10'h3F8;
      2'd1:    return 10'h2F8;
      2'd2:    return c3;
      default: return c4;
    endcase
  endfunction

  assign diff = cmd.wrData ^ cfgRegs[cmd.regIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) cfgRegs[i] <= resetVal(i);
      upd <= '0;
    end else begin
      if (cmd.regWr) cfgRegs[cmd.regIdx] <= cmd.wrData;
      upd.lpt   <= cmd.regWr && cmd.regIdx == 4'd1 && |diff[1:0];
      upd.com34 <= cmd.regWr && cmd.regIdx == 4'd1 && |diff[6:5];
      upd.ser1  <= cmd.regWr && cmd.regIdx == 4'd2 && |diff[2:0];
      upd.ser2  <= cmd.regWr && cmd.regIdx == 4'd2 && |diff[6:4];
      upd.fdc   <= cmd.regWr && ((cmd.regIdx == 4'd3 && diff[1]) ||
                                 (cmd.regIdx == 4'd5 && |diff[5:3]));
    end
  end

  assign rdReg = cfgRegs[rdIdx];

  always_comb begin
    lptEn = |cfgRegs[1][1:0];
    case (cfgRegs[1][1:0])
      2'd0:    lptBase = 10'h000;
      2'd1:    lptBase = 10'h3BC;
      2'd2:    lptBase = 10'h378;
      default: lptBase = 10'h278;
    endcase
    case (cfgRegs[1][6:5])
      2'd0:    begin com3Base = 10'h338; com4Base = 10'h238; end
      2'd1:    begin com3Base = 10'h3E8; com4Base = 10'h2E8; end
      2'd2:    begin com3Base = 10'h3E8; com4Base = 10'h2E0; end
      default: begin com3Base = 10'h220; com4Base = 10'h228; end
    endcase
  end

  assign ser1En   = cfgRegs[2][2];
  assign ser1Base = serBaseOf(cfgRegs[2][1:0], com3Base, com4Base);
  assign ser1Irq  = cfgRegs[2][0] ? 4'd3 : 4'd4;
  assign ser2En   = cfgRegs[2][6];
  assign ser2Base = serBaseOf(cfgRegs[2][5:4], com3Base, com4Base);
  assign ser2Irq  = cfgRegs[2][4] ? 4'd3 : 4'd4;

  assign fdcEnhMode     = cfgRegs[3][1];
  assign fdcDenselForce = cfgRegs[5][4:3];
  assign fdcDriveSwap   = cfgRegs[5][5];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter logic [7:0] DEVICE_ID = 8'h63,
  parameter logic [15:0] IDX_PORT = 16'h03F0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  ioWrData,
  input  logic        ioWr,
  output logic [7:0]  ioRdData,
  output logic        fdcDataDecodeEn,
  output logic        lptEn,
  output logic [9:0]  lptBase,
  output logic [9:0]  com3Base,
  output logic [9:0]  com4Base,
  output logic        ser1En,
  output logic [9:0]  ser1Base,
  output logic [3:0]  ser1Irq,
  output logic        ser2En,
  output logic [9:0]  ser2Base,
  output logic [3:0]  ser2Irq,
  output logic        fdcEnhMode,
  output logic [1:0]  fdcDenselForce,
  output logic        fdcDriveSwap,
  output logic        lptUpd,
  output logic        com34Upd,
  output logic        ser1Upd,
  output logic        ser2Upd,
  output logic        fdcUpd
);
  cfgCmd_t    cmd;
  cfgUpd_t    upd;
  logic       unlocked, idxValid;
  logic [3:0] curIdx;
  logic [7:0] rdReg;

  sio_cfg_ctrl #(.ADDR_W(16), .DATA_W(8), .NUM_REGS(NUM_REGS), .IDX_PORT(IDX_PORT)) uCtrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .cmd(cmd), .unlocked(unlocked), .idxValid(idxValid), .curIdx(curIdx),
    .fdcDataDecodeEn(fdcDataDecodeEn)
  );

  sio_cfg_regs #(.NUM_REGS(NUM_REGS), .DEVICE_ID(DEVICE_ID)) uRegs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdIdx(curIdx), .rdReg(rdReg), .upd(upd),
    .lptEn(lptEn), .lptBase(lptBase), .com3Base(com3Base), .com4Base(com4Base),
    .ser1En(ser1En), .ser1Base(ser1Base), .ser1Irq(ser1Irq),
    .ser2En(ser2En), .ser2Base(ser2Base), .ser2Irq(ser2Irq),
    .fdcEnhMode(fdcEnhMode), .fdcDenselForce(fdcDenselForce), .fdcDriveSwap(fdcDriveSwap)
  );

  assign ioRdData = (ioAddr == IDX_PORT + 16'd1 && unlocked && idxValid) ? rdReg : READ_IDLE;
  assign lptUpd   = upd.lpt;
  assign com34Upd = upd.com34;
  assign ser1Upd  = upd.ser1;
  assign ser2Upd  = upd.ser2;
  assign fdcUpd   = upd.fdc;
endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] ioAddr,
  input logic [7:0]  ioWrData,
  input logic        ioWr,
  input logic [7:0]  ioRdData,
  input logic        unlocked,
  input logic        fdcDataDecodeEn,
  input logic [9:0]  lptBase,
  input logic [9:0]  ser1Base,
  input logic        lptUpd,
  input logic        fdcUpd
);
  // R6
  locked_read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr == 16'h03F1 && !unlocked) |-> ioRdData == 8'hFF);

  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(ioWr && ioAddr == 16'h03F0 && ioWrData == 8'h55));

  // R5
  decode_drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fdcDataDecodeEn) |-> $past(ioWr && ioAddr == 16'h03F0 && ioWrData == 8'h55));

  // R13
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lptUpd || fdcUpd) |-> $past(ioWr && ioAddr == 16'h03F1 && unlocked));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioWr && ioAddr == 16'h03F1 && unlocked) |-> ($stable(lptBase) && $stable(ser1Base)));
endmodule

bind sio_cfg_port sio_cfg_chk uChk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
  .ioRdData(ioRdData), .unlocked(unlocked), .fdcDataDecodeEn(fdcDataDecodeEn),
  .lptBase(lptBase), .ser1Base(ser1Base), .lptUpd(lptUpd), .fdcUpd(fdcUpd)
);

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;
  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] ioAddr = 0;
  logic [7:0]  ioWrData = 0;
  logic        ioWr = 0;
  logic [7:0]  ioRdData;
  logic        fdcDataDecodeEn, lptEn, ser1En, ser2En, fdcEnhMode, fdcDriveSwap;
  logic [9:0]  lptBase, com3Base, com4Base, ser1Base, ser2Base;
  logic [3:0]  ser1Irq, ser2Irq;
  logic [1:0]  fdcDenselForce;
  logic        lptUpd, com34Upd, ser1Upd, ser2Upd, fdcUpd;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [16];
  logic [7:0] prev, rv;

  always #2 clk = ~clk;

  sio_cfg_port dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRdData(ioRdData), .fdcDataDecodeEn(fdcDataDecodeEn), .lptEn(lptEn),
    .lptBase(lptBase), .com3Base(com3Base), .com4Base(com4Base),
    .ser1En(ser1En), .ser1Base(ser1Base), .ser1Irq(ser1Irq),
    .ser2En(ser2En), .ser2Base(ser2Base), .ser2Irq(ser2Irq),
    .fdcEnhMode(fdcEnhMode), .fdcDenselForce(fdcDenselForce), .fdcDriveSwap(fdcDriveSwap),
    .lptUpd(lptUpd), .com34Upd(com34Upd), .ser1Upd(ser1Upd), .ser2Upd(ser2Upd), .fdcUpd(fdcUpd)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; back-to-back calls give consecutive cycles
  task automatic wr(logic [15:0] a, logic [7:0] d);
    ioAddr = a; ioWrData = d; ioWr = 1;
    @(posedge clk); @(negedge clk);
    ioWr = 0; ioAddr = 16'h0000;
  endtask

  task automatic rd(output logic [7:0] v);
    ioAddr = 16'h03F1; #1; v = ioRdData; ioAddr = 16'h0000;
  endtask

  function automatic logic [9:0] lptExp(logic [1:0] s);
    case (s) 2'd0: return 10'h000; 2'd1: return 10'h3BC; 2'd2: return 10'h378; default: return 10'h278; endcase
  endfunction
  function automatic logic [9:0] c3Exp(logic [1:0] c);
    case (c) 2'd0: return 10'h338; 2'd1, 2'd2: return 10'h3E8; default: return 10'h220; endcase
  endfunction
  function automatic logic [9:0] c4Exp(logic [1:0] c);
    case (c) 2'd0: return 10'h238; 2'd1: return 10'h2E8; 2'd2: return 10'h2E0; default: return 10'h228; endcase
  endfunction
  function automatic logic [9:0] serExp(logic [1:0] s, logic [1:0] c);
    case (s) 2'd0: return 10'h3F8; 2'd1: return 10'h2F8; 2'd2: return c3Exp(c); default: return c4Exp(c); endcase
  endfunction

  // Writes one register; checks strobes in the cycle after the data write (R13)
  task automatic setReg(int i, logic [7:0] v);
    logic [7:0] x;
    x = mdl[i] ^ v;
    wr(16'h03F0, 8'(i));
    wr(16'h03F1, v);
    mdl[i] = v;
    chk("R13 lptUpd",   lptUpd,   i == 1 && |x[1:0]);
    chk("R13 com34Upd", com34Upd, i == 1 && |x[6:5]);
    chk("R13 ser1Upd",  ser1Upd,  i == 2 && |x[2:0]);
    chk("R13 ser2Upd",  ser2Upd,  i == 2 && |x[6:4]);
    chk("R13 fdcUpd",   fdcUpd,   (i == 3 && x[1]) || (i == 5 && |x[5:3]));
  endtask

  task automatic chkDecode();
    chk("R9 lptEn",     lptEn,    |mdl[1][1:0]);
    chk("R9 lptBase",   lptBase,  lptExp(mdl[1][1:0]));
    chk("R10 com3Base", com3Base, c3Exp(mdl[1][6:5]));
    chk("R10 com4Base", com4Base, c4Exp(mdl[1][6:5]));
    chk("R11 ser1En",   ser1En,   mdl[2][2]);
    chk("R11 ser1Base", ser1Base, serExp(mdl[2][1:0], mdl[1][6:5]));
    chk("R11 ser1Irq",  ser1Irq,  mdl[2][0] ? 3 : 4);
    chk("R11 ser2En",   ser2En,   mdl[2][6]);
    chk("R11 ser2Base", ser2Base, serExp(mdl[2][5:4], mdl[1][6:5]));
    chk("R11 ser2Irq",  ser2Irq,  mdl[2][4] ? 3 : 4);
    chk("R12 fdcEnhMode", fdcEnhMode, mdl[3][1]);
    chk("R12 densel",     fdcDenselForce, mdl[5][4:3]);
    chk("R12 swap",       fdcDriveSwap, mdl[5][5]);
  endtask

  task automatic sweepRead(string tag);
    for (int i = 0; i < 16; i++) begin
      wr(16'h03F0, 8'(i));
      rd(rv);
      chk(tag, rv, mdl[i]);
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h3A; mdl[1] = 8'h9F; mdl[2] = 8'hDC; mdl[3] = 8'h78;
    mdl[6] = 8'hFF; mdl[13] = 8'h63; mdl[14] = 8'h01;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R8 reset decode, R5 reset enable, R6 locked read
    chkDecode();
    chk("R5 reset decode enable", fdcDataDecodeEn, 1);
    chk("R13 reset strobes", {lptUpd, com34Upd, ser1Upd, ser2Upd, fdcUpd}, 0);
    rd(rv); chk("R6 locked read", rv, 8'hFF);

    // R1 other addresses ignored
    wr(16'h03F2, 8'h55); wr(16'h03F2, 8'h55);
    wr(16'h13F0, 8'h55); wr(16'h13F0, 8'h55);
    rd(rv); chk("R1 stray address no unlock", rv, 8'hFF);
    chk("R1 stray address decode enable", fdcDataDecodeEn, 1);

    // R2 unlock, R5 decode drop
    wr(16'h03F0, 8'h55);
    chk("R5 single key keeps enable", fdcDataDecodeEn, 1);
    rd(rv); chk("R2 one key still locked", rv, 8'hFF);
    wr(16'h03F0, 8'h55);
    chk("R5 second key drops enable", fdcDataDecodeEn, 0);
    rd(rv); chk("R2 unlocked read reg0", rv, 8'h3A);

    // R4 index select, R8 reset values
    sweepRead("R8 reset value");

    // R6/R7 index above 15
    wr(16'h03F0, 8'h40);
    rd(rv); chk("R6 out-of-range index read", rv, 8'hFF);
    wr(16'h03F1, 8'h12);
    chk("R7 out-of-range strobe", {lptUpd, com34Upd, ser1Upd, ser2Upd, fdcUpd}, 0);
    sweepRead("R7 out-of-range write ignored");

    // R9/R10/R13 exhaustive over register 1
    for (int v = 0; v < 256; v++) begin setReg(1, 8'(v)); chkDecode(); end
    setReg(1, 8'h9F); chkDecode();  // same value -> no strobe

    // R11 exhaustive register 2 for every COM3/COM4 pair
    for (int c = 0; c < 4; c++) begin
      setReg(1, {1'b0, 2'(c), 5'b00010});
      for (int v = 0; v < 256; v++) begin setReg(2, 8'(v)); chkDecode(); end
    end

    // R12 exhaustive registers 3 and 5
    for (int v = 0; v < 256; v++) begin setReg(3, 8'(v)); chkDecode(); end
    for (int v = 0; v < 256; v++) begin setReg(5, 8'(v)); chkDecode(); end
    sweepRead("R4 readback after sweeps");

    // Same-cycle: strobe of a data write while the lock write is taken
    prev = mdl[1];
    wr(16'h03F0, 8'h01);
    wr(16'h03F1, prev ^ 8'h03);
    mdl[1] = prev ^ 8'h03;
    chk("R13 strobe during lock write", lptUpd, 1);
    wr(16'h03F0, 8'hAA);
    chk("R13 strobe one cycle only", lptUpd, 0);
    rd(rv); chk("R4 lock with 0xAA", rv, 8'hFF);
    chk("R5 enable restored on lock", fdcDataDecodeEn, 1);
    chkDecode();

    // R3 locked index write, R7 locked data write
    wr(16'h03F0, 8'h07);
    wr(16'h03F1, 8'h00);
    wr(16'h03F0, 8'h55);
    chk("R5 key after non-key keeps enable", fdcDataDecodeEn, 1);
    wr(16'h03F0, 8'h55);
    chk("R5 relock drop", fdcDataDecodeEn, 0);
    rd(rv); chk("R3 index kept while locked", rv, mdl[1]);
    chkDecode();
    sweepRead("R7 locked write ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule